// File: doc/BRIEF.md
# Adaptive Context Probability State Store

This block keeps the adaptive probability state of a binary arithmetic encoder that codes with 19 contexts. For every context it stores a sense bit, which names the more probable symbol, and a 6-bit state number. The state number selects a row of a fixed 47-row estimation table. Each row gives a 16-bit less-probable-symbol probability, the state to move to after a more-probable outcome, the state to move to after a less-probable outcome, and a flag that says whether the sense bit flips on a less-probable outcome.

Next to each probability, the block also gives two derived values. The first is the count of leading zero bits in the 16-bit probability. The second is the probability already shifted left by that count. With these, the interval stage can load a new interval without a shifter in its path.

The block has two ports. The read port is combinational: it takes a context number and returns that context's state and the whole table row. The update port takes a context number, the coded decision bit and a flag that says whether a more-probable outcome caused renormalization. The update is written at the next rising clock edge. A read of the same context in the cycle of its update already returns the new state.

Top module: `ctx_prob_state`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets every context to state 0 with sense bit 0. Any update presented while `rst` is high is discarded. This includes the same-cycle forwarding of R9.
- R2: `rd_mps` and `rd_idx` show the stored sense bit and state number of context `rd_ctx`. The fields `rd_qe`, `rd_nmps`, `rd_nlps` and `rd_switch` show the table row of `rd_idx`. Examples: row 0 holds 0x5601, 1, 1, 1; row 5 holds 0x0221, 38, 33, 0; row 45 holds 0x0001, 45, 43, 0; row 46 holds 0x5601, 46, 46, 0.
- R3: `rd_lzc` equals the number of leading zero bits of `rd_qe` in a 16-bit word. For example, 0x5601 gives 1 and 0x0001 gives 15.
- R4: `rd_qe_norm` equals `rd_qe` shifted left by `rd_lzc`, kept to 16 bits, so its bit 15 is 1. For example, 0x5601 gives 0xAC02.
- R5: An update whose decision differs from the context's sense bit is a less-probable outcome. It sets the state number to the current row's next-on-LPS value, and it inverts the sense bit when that row's switch flag is 1.
- R6: An update whose decision equals the sense bit, with `upd_renorm` = 1, sets the state number to the next-on-MPS value and keeps the sense bit.
- R7: An update whose decision equals the sense bit, with `upd_renorm` = 0, leaves the context unchanged.
- R8: An update changes only the context named by `upd_ctx`. All other contexts keep their state.
- R9: When `upd_en` = 1 and `rd_ctx` = `upd_ctx` in the same cycle, the read port shows the state that the update writes, together with that state's table row.
- R10: A context number of 19 or more on the update port changes nothing. On the read port, such a number returns state 0 with sense bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Apply an update at the next edge |
| upd_ctx | input | 5 | Context number to update |
| upd_dec | input | 1 | Coded decision bit |
| upd_renorm | input | 1 | A more-probable outcome caused renormalization |
| rd_ctx | input | 5 | Context number to read |
| rd_mps | output | 1 | Sense bit of the read context |
| rd_idx | output | 6 | State number of the read context |
| rd_qe | output | 16 | Less-probable-symbol probability |
| rd_nmps | output | 6 | Next state after a more-probable outcome |
| rd_nlps | output | 6 | Next state after a less-probable outcome |
| rd_switch | output | 1 | Sense inversion flag |
| rd_lzc | output | 5 | Leading zero count of `rd_qe` |
| rd_qe_norm | output | 16 | `rd_qe` shifted so that its top bit is set |

## Verification
The bench builds two copies of the block with the default 19 contexts and 16-bit probabilities. The first copy takes the derived values from tables filled at elaboration. The second copy computes them with a priority encoder at run time. Both copies are compared against the same reference model, so the two variants are checked against one another.

A 5-bit context number makes the codes 19 to 31 reachable, which exercises R10. A long run of renormalizing more-probable outcomes walks a context down to row 45, where the probability has 15 leading zeros.

// File: rtl/ctx_prob_pkg.sv
package ctx_prob_pkg;

   localparam int PKG_QE_W    = 16;
   localparam int PKG_IDX_W   = 6;
   localparam int PKG_NUM_IDX = 47;
   localparam int PKG_LZC_W   = 5;

   typedef struct packed {
      logic [PKG_QE_W-1:0]  qe;
      logic [PKG_IDX_W-1:0] nmps;
      logic [PKG_IDX_W-1:0] nlps;
      logic                 sw;
   } prob_row_t;

   function automatic prob_row_t mk_row(input logic [15:0] q, input int m, input int l, input bit s);
      prob_row_t r;
      r.qe   = q;
      r.nmps = PKG_IDX_W'(m);
      r.nlps = PKG_IDX_W'(l);
      r.sw   = s;
      return r;
   endfunction

   // Fixed estimation table; rows outside the table read as zero.
   function automatic prob_row_t row_of(input int k);
      case (k)
         0:  return mk_row(16'h5601,  1,  1, 1'b1);
         1:  return mk_row(16'h3401,  2,  6, 1'b0);
         2:  return mk_row(16'h1801,  3,  9, 1'b0);
         3:  return mk_row(16'h0AC1,  4, 12, 1'b0);
         4:  return mk_row(16'h0521,  5, 29, 1'b0);
         5:  return mk_row(16'h0221, 38, 33, 1'b0);
         6:  return mk_row(16'h5601,  7,  6, 1'b1);
         7:  return mk_row(16'h5401,  8, 14, 1'b0);
         8:  return mk_row(16'h4801,  9, 14, 1'b0);
         9:  return mk_row(16'h3801, 10, 14, 1'b0);
         10: return mk_row(16'h3001, 11, 17, 1'b0);
         11: return mk_row(16'h2401, 12, 18, 1'b0);
         12: return mk_row(16'h1C01, 13, 20, 1'b0);
         13: return mk_row(16'h1601, 29, 21, 1'b0);
         14: return mk_row(16'h5601, 15, 14, 1'b1);
         15: return mk_row(16'h5401, 16, 14, 1'b0);
         16: return mk_row(16'h5101, 17, 15, 1'b0);
         17: return mk_row(16'h4801, 18, 16, 1'b0);
         18: return mk_row(16'h3801, 19, 17, 1'b0);
         19: return mk_row(16'h3401, 20, 18, 1'b0);
         20: return mk_row(16'h3001, 21, 19, 1'b0);
         21: return mk_row(16'h2801, 22, 19, 1'b0);
         22: return mk_row(16'h2401, 23, 20, 1'b0);
         23: return mk_row(16'h2201, 24, 21, 1'b0);
         24: return mk_row(16'h1C01, 25, 22, 1'b0);
         25: return mk_row(16'h1801, 26, 23, 1'b0);
         26: return mk_row(16'h1601, 27, 24, 1'b0);
         27: return mk_row(16'h1401, 28, 25, 1'b0);
         28: return mk_row(16'h1201, 29, 26, 1'b0);
         29: return mk_row(16'h1101, 30, 27, 1'b0);
         30: return mk_row(16'h0AC1, 31, 28, 1'b0);
         31: return mk_row(16'h09C1, 32, 29, 1'b0);
         32: return mk_row(16'h08A1, 33, 30, 1'b0);
         33: return mk_row(16'h0521, 34, 31, 1'b0);
         34: return mk_row(16'h0441, 35, 32, 1'b0);
         35: return mk_row(16'h02A1, 36, 33, 1'b0);
         36: return mk_row(16'h0221, 37, 34, 1'b0);
         37: return mk_row(16'h0141, 38, 35, 1'b0);
         38: return mk_row(16'h0111, 39, 36, 1'b0);
         39: return mk_row(16'h0085, 40, 37, 1'b0);
         40: return mk_row(16'h0049, 41, 38, 1'b0);
         41: return mk_row(16'h0025, 42, 39, 1'b0);
         42: return mk_row(16'h0015, 43, 40, 1'b0);
         43: return mk_row(16'h0009, 44, 41, 1'b0);
         44: return mk_row(16'h0005, 45, 42, 1'b0);
         45: return mk_row(16'h0001, 45, 43, 1'b0);
         46: return mk_row(16'h5601, 46, 46, 1'b0);
         default: return '0;
      endcase
   endfunction

   // Leading zero count of a probability word (full width when zero).
   function automatic logic [PKG_LZC_W-1:0] lzc_of(input logic [PKG_QE_W-1:0] v);
      int  n;
      bit  hit;
      n   = 0;
      hit = 1'b0;
      for (int b = PKG_QE_W - 1; b >= 0; b--) begin
         if (!hit) begin
            if (v[b]) hit = 1'b1;
            else      n   = n + 1;
         end
      end
      return PKG_LZC_W'(n);
   endfunction

endpackage

// File: rtl/prob_table_rom.sv
module prob_table_rom
   import ctx_prob_pkg::*;
#(
   parameter int IDX_W   = 6,
   parameter int QE_W    = 16,
   parameter int LZC_W   = 5,
   parameter int NUM_IDX = 47,
   parameter bit PRECOMP = 1'b1
)(
   input  logic [IDX_W-1:0] idx,
   output logic [QE_W-1:0]  qe_o,
   output logic [IDX_W-1:0] nmps_o,
   output logic [IDX_W-1:0] nlps_o,
   output logic             sw_o,
   output logic [LZC_W-1:0] lzc_o,
   output logic [QE_W-1:0]  norm_o
);

   generate
      if (PRECOMP) begin : g_tab
         // Derived columns are filled at elaboration; the read is a plain mux.
         logic [QE_W-1:0]  qe_tab   [NUM_IDX];
         logic [IDX_W-1:0] nmps_tab [NUM_IDX];
         logic [IDX_W-1:0] nlps_tab [NUM_IDX];
         logic             sw_tab   [NUM_IDX];
         logic [LZC_W-1:0] lzc_tab  [NUM_IDX];
         logic [QE_W-1:0]  norm_tab [NUM_IDX];

         for (genvar k = 0; k < NUM_IDX; k++) begin : g_ent
            localparam prob_row_t ROW = row_of(k);
            localparam logic [LZC_W-1:0] LZ = LZC_W'(lzc_of(ROW.qe));
            assign qe_tab[k]   = ROW.qe;
            assign nmps_tab[k] = ROW.nmps;
            assign nlps_tab[k] = ROW.nlps;
            assign sw_tab[k]   = ROW.sw;
            assign lzc_tab[k]  = LZ;
            assign norm_tab[k] = ROW.qe << LZ;
         end

         always_comb begin
            qe_o   = '0;
            nmps_o = '0;
            nlps_o = '0;
            sw_o   = 1'b0;
            lzc_o  = LZC_W'(QE_W);
            norm_o = '0;
            if (int'(idx) < NUM_IDX) begin
               qe_o   = qe_tab[idx];
               nmps_o = nmps_tab[idx];
               nlps_o = nlps_tab[idx];
               sw_o   = sw_tab[idx];
               lzc_o  = lzc_tab[idx];
               norm_o = norm_tab[idx];
            end
         end
      end else begin : g_calc
         // Derived columns come from a priority encoder behind the table read.
         always_comb begin
            prob_row_t        r;
            logic [LZC_W-1:0] lz;
            logic             hit;
            r   = row_of(int'(idx));
            lz  = '0;
            hit = 1'b0;
            for (int b = QE_W - 1; b >= 0; b--) begin
               if (!hit) begin
                  if (r.qe[b]) hit = 1'b1;
                  else         lz  = lz + LZC_W'(1);
               end
            end
            qe_o   = r.qe;
            nmps_o = r.nmps;
            nlps_o = r.nlps;
            sw_o   = r.sw;
            lzc_o  = lz;
            norm_o = r.qe << lz;
         end
      end
   endgenerate

   always_comb begin
      if (qe_o != '0) begin
         a_r4_norm_top_set: assert (norm_o[QE_W-1])
            else $error("R4: normalised probability lacks its top bit");
         a_r3_lzc_marks_msb: assert ((qe_o >> (QE_W - 1 - int'(lzc_o))) == QE_W'(1))
            else $error("R3: leading zero count does not locate the top set bit");
      end
   end

endmodule

// File: rtl/ctx_next_state.sv
module ctx_next_state #(
   parameter int IDX_W = 6
)(
   input  logic             cur_mps,
   input  logic [IDX_W-1:0] cur_idx,
   input  logic [IDX_W-1:0] tbl_nmps,
   input  logic [IDX_W-1:0] tbl_nlps,
   input  logic             tbl_sw,
   input  logic             dec,
   input  logic             renorm,
   output logic             nxt_mps,
   output logic [IDX_W-1:0] nxt_idx,
   output logic             nxt_we
);

   logic is_lps;
   assign is_lps = dec ^ cur_mps;

   always_comb begin
      nxt_mps = cur_mps;
      nxt_idx = cur_idx;
      nxt_we  = 1'b0;
      if (is_lps) begin
         nxt_idx = tbl_nlps;
         nxt_mps = cur_mps ^ tbl_sw;
         nxt_we  = 1'b1;
      end else if (renorm) begin
         nxt_idx = tbl_nmps;
         nxt_we  = 1'b1;
      end
   end

endmodule

// File: rtl/ctx_state_file.sv
module ctx_state_file #(
   parameter int NUM_CTX = 19,
   parameter int IDX_W   = 6,
   parameter int CTX_W   = 5
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             upd_en,
   input  logic [CTX_W-1:0] upd_ctx,
   input  logic             upd_we,
   input  logic             nxt_mps,
   input  logic [IDX_W-1:0] nxt_idx,
   input  logic [CTX_W-1:0] rd_ctx,
   output logic             cur_mps,
   output logic [IDX_W-1:0] cur_idx,
   output logic             rd_mps,
   output logic [IDX_W-1:0] rd_idx
);

   logic [NUM_CTX-1:0]            mps_q;
   logic [NUM_CTX-1:0][IDX_W-1:0] idx_q;
   logic                          upd_ok;
   logic                          wr;

   assign upd_ok = int'(upd_ctx) < NUM_CTX;
   assign wr     = upd_en & upd_ok & upd_we & ~rst;

   always_ff @(posedge clk) begin
      if (rst) begin
         mps_q <= '0;
         idx_q <= '0;
      end else begin
         for (int c = 0; c < NUM_CTX; c++) begin
            if (wr && upd_ctx == CTX_W'(c)) begin
               mps_q[c] <= nxt_mps;
               idx_q[c] <= nxt_idx;
            end
         end
      end
   end

   always_comb begin
      cur_mps = 1'b0;
      cur_idx = '0;
      rd_mps  = 1'b0;
      rd_idx  = '0;
      for (int c = 0; c < NUM_CTX; c++) begin
         if (upd_ctx == CTX_W'(c)) begin
            cur_mps = mps_q[c];
            cur_idx = idx_q[c];
         end
         if (rd_ctx == CTX_W'(c)) begin
            rd_mps = mps_q[c];
            rd_idx = idx_q[c];
         end
      end
      // Same-cycle forwarding of the value being written.
      if (wr && rd_ctx == upd_ctx) begin
         rd_mps = nxt_mps;
         rd_idx = nxt_idx;
      end
   end

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (mps_q == '0 && idx_q == '0))
      else $error("R1: state not cleared by reset");

   a_r7_hold_keeps_state: assert property (@(posedge clk) disable iff (rst)
      (upd_en && !upd_we) |=> ($stable(mps_q) && $stable(idx_q)))
      else $error("R7: non-renormalising MPS changed state");

   a_r10_oob_ignored: assert property (@(posedge clk) disable iff (rst)
      (upd_en && int'(upd_ctx) >= NUM_CTX) |=> ($stable(mps_q) && $stable(idx_q)))
      else $error("R10: out-of-range update changed state");

   for (genvar g = 0; g < NUM_CTX; g++) begin : g_chk
      a_r8_others_kept: assert property (@(posedge clk) disable iff (rst)
         (!upd_en || upd_ctx != CTX_W'(g)) |=> ($stable(mps_q[g]) && $stable(idx_q[g])))
         else $error("R8: context changed without being addressed");
   end

endmodule

// File: rtl/ctx_prob_state.sv
module ctx_prob_state
   import ctx_prob_pkg::*;
#(
   parameter int NUM_CTX = 19,
   parameter int IDX_W   = 6,
   parameter int QE_W    = 16,
   parameter bit PRECOMP = 1'b1,
   localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   localparam int LZC_W  = $clog2(QE_W + 1)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             upd_en,
   input  logic [CTX_W-1:0] upd_ctx,
   input  logic             upd_dec,
   input  logic             upd_renorm,
   input  logic [CTX_W-1:0] rd_ctx,
   output logic             rd_mps,
   output logic [IDX_W-1:0] rd_idx,
   output logic [QE_W-1:0]  rd_qe,
   output logic [IDX_W-1:0] rd_nmps,
   output logic [IDX_W-1:0] rd_nlps,
   output logic             rd_switch,
   output logic [LZC_W-1:0] rd_lzc,
   output logic [QE_W-1:0]  rd_qe_norm
);

   initial begin
      a_cfg_widths: assert (QE_W == PKG_QE_W && IDX_W == PKG_IDX_W && LZC_W == PKG_LZC_W)
         else $fatal(1, "table widths do not match the package");
      a_cfg_ctx: assert (NUM_CTX >= 1 && NUM_CTX <= (1 << CTX_W))
         else $fatal(1, "context count out of range");
   end

   logic             cur_mps;
   logic [IDX_W-1:0] cur_idx;
   logic [IDX_W-1:0] b_nmps;
   logic [IDX_W-1:0] b_nlps;
   logic             b_sw;
   logic [QE_W-1:0]  b_qe_unused;
   logic [LZC_W-1:0] b_lzc_unused;
   logic [QE_W-1:0]  b_norm_unused;
   logic             nxt_mps;
   logic [IDX_W-1:0] nxt_idx;
   logic             nxt_we;

   ctx_state_file #(
      .NUM_CTX (NUM_CTX),
      .IDX_W   (IDX_W),
      .CTX_W   (CTX_W)
   ) u_state (
      .clk     (clk),
      .rst     (rst),
      .upd_en  (upd_en),
      .upd_ctx (upd_ctx),
      .upd_we  (nxt_we),
      .nxt_mps (nxt_mps),
      .nxt_idx (nxt_idx),
      .rd_ctx  (rd_ctx),
      .cur_mps (cur_mps),
      .cur_idx (cur_idx),
      .rd_mps  (rd_mps),
      .rd_idx  (rd_idx)
   );

   prob_table_rom #(
      .IDX_W   (IDX_W),
      .QE_W    (QE_W),
      .LZC_W   (LZC_W),
      .NUM_IDX (PKG_NUM_IDX),
      .PRECOMP (PRECOMP)
   ) u_rom_upd (
      .idx    (cur_idx),
      .qe_o   (b_qe_unused),
      .nmps_o (b_nmps),
      .nlps_o (b_nlps),
      .sw_o   (b_sw),
      .lzc_o  (b_lzc_unused),
      .norm_o (b_norm_unused)
   );

   ctx_next_state #(
      .IDX_W (IDX_W)
   ) u_next (
      .cur_mps  (cur_mps),
      .cur_idx  (cur_idx),
      .tbl_nmps (b_nmps),
      .tbl_nlps (b_nlps),
      .tbl_sw   (b_sw),
      .dec      (upd_dec),
      .renorm   (upd_renorm),
      .nxt_mps  (nxt_mps),
      .nxt_idx  (nxt_idx),
      .nxt_we   (nxt_we)
   );

   prob_table_rom #(
      .IDX_W   (IDX_W),
      .QE_W    (QE_W),
      .LZC_W   (LZC_W),
      .NUM_IDX (PKG_NUM_IDX),
      .PRECOMP (PRECOMP)
   ) u_rom_rd (
      .idx    (rd_idx),
      .qe_o   (rd_qe),
      .nmps_o (rd_nmps),
      .nlps_o (rd_nlps),
      .sw_o   (rd_switch),
      .lzc_o  (rd_lzc),
      .norm_o (rd_qe_norm)
   );

   a_r9_forward_same_ctx: assert property (@(posedge clk) disable iff (rst)
      (upd_en && int'(upd_ctx) < NUM_CTX && rd_ctx == upd_ctx) |=> (int'(rd_ctx) >= NUM_CTX || !$stable(rd_ctx) || upd_en || (rd_mps == $past(rd_mps) && rd_idx == $past(rd_idx))))
      else $error("R9: forwarded state differs from the stored state");

endmodule

// File: tb/ctx_prob_state_tb.sv
module ctx_prob_state_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NCTX       = 19;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic       rst = 1'b1;
   logic       upd_en = 1'b0;
   logic [4:0] upd_ctx = '0;
   logic       upd_dec = 1'b0;
   logic       upd_renorm = 1'b0;
   logic [4:0] rd_ctx = '0;

   logic       a_mps, c_mps;
   logic [5:0] a_idx, a_nmps, a_nlps, c_idx, c_nmps, c_nlps;
   logic [15:0] a_qe, a_norm, c_qe, c_norm;
   logic       a_sw, c_sw;
   logic [4:0] a_lzc, c_lzc;

   ctx_prob_state #(.PRECOMP(1'b1)) u_dut (
      .clk(clk), .rst(rst), .upd_en(upd_en), .upd_ctx(upd_ctx), .upd_dec(upd_dec),
      .upd_renorm(upd_renorm), .rd_ctx(rd_ctx), .rd_mps(a_mps), .rd_idx(a_idx),
      .rd_qe(a_qe), .rd_nmps(a_nmps), .rd_nlps(a_nlps), .rd_switch(a_sw),
      .rd_lzc(a_lzc), .rd_qe_norm(a_norm));

   ctx_prob_state #(.PRECOMP(1'b0)) u_dut_calc (
      .clk(clk), .rst(rst), .upd_en(upd_en), .upd_ctx(upd_ctx), .upd_dec(upd_dec),
      .upd_renorm(upd_renorm), .rd_ctx(rd_ctx), .rd_mps(c_mps), .rd_idx(c_idx),
      .rd_qe(c_qe), .rd_nmps(c_nmps), .rd_nlps(c_nlps), .rd_switch(c_sw),
      .rd_lzc(c_lzc), .rd_qe_norm(c_norm));

   int qe_t[47] = '{'h5601,'h3401,'h1801,'h0AC1,'h0521,'h0221,'h5601,'h5401,'h4801,'h3801,
                    'h3001,'h2401,'h1C01,'h1601,'h5601,'h5401,'h5101,'h4801,'h3801,'h3401,
                    'h3001,'h2801,'h2401,'h2201,'h1C01,'h1801,'h1601,'h1401,'h1201,'h1101,
                    'h0AC1,'h09C1,'h08A1,'h0521,'h0441,'h02A1,'h0221,'h0141,'h0111,'h0085,
                    'h0049,'h0025,'h0015,'h0009,'h0005,'h0001,'h5601};
   int nm_t[47] = '{1,2,3,4,5,38,7,8,9,10,11,12,13,29,15,16,17,18,19,20,21,22,23,24,
                    25,26,27,28,29,30,31,32,33,34,35,36,37,38,39,40,41,42,43,44,45,45,46};
   int nl_t[47] = '{1,6,9,12,29,33,6,14,14,14,17,18,20,21,14,14,15,16,17,18,19,19,20,21,
                    22,23,24,25,26,27,28,29,30,31,32,33,34,35,36,37,38,39,40,41,42,43,46};
   int sw_t[47] = '{1,0,0,0,0,0,1,0,0,0,0,0,0,0,1,0,0,0,0,0,0,0,0,0,
                    0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0};

   int m_idx[NCTX];
   int m_mps[NCTX];
   int m_kind[NCTX];
   bit model_ok = 1'b0;
   int prev_upd = -1;
   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input string what, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
      end
   endtask

   function automatic int lz16(input int q);
      for (int b = 15; b >= 0; b--) if (((q >> b) & 1) == 1) return 15 - b;
      return 16;
   endfunction

   // Reference next state; kind 5 = LPS, 6 = renormalising MPS, 7 = plain MPS.
   task automatic ref_next(input int c, input bit d, input bit rn,
                           output int ni, output int nm, output int kind);
      ni = m_idx[c];
      nm = m_mps[c];
      if (int'(d) != m_mps[c]) begin
         ni = nl_t[m_idx[c]];
         if (sw_t[m_idx[c]] == 1) nm = 1 - m_mps[c];
         kind = 5;
      end else if (rn) begin
         ni = nm_t[m_idx[c]];
         kind = 6;
      end else begin
         kind = 7;
      end
   endtask

   function automatic string kind_tag(input int k);
      case (k)
         5: return "R5";
         6: return "R6";
         7: return "R7";
         default: return "R1";
      endcase
   endfunction

   task automatic step(input bit r, input bit e, input int uc, input bit d, input bit rn, input int rc);
      int ei, em, kd, ni, nm, lz, nq;
      string tag;
      @(negedge clk);
      rst = r; upd_en = e; upd_ctx = 5'(uc); upd_dec = d; upd_renorm = rn; rd_ctx = 5'(rc);
      #1;
      if (model_ok) begin
         if (rc >= NCTX) begin
            ei = 0; em = 0; tag = "R10";
         end else if (e && !r && uc == rc) begin
            ref_next(uc, d, rn, ei, em, kd); tag = "R9";
         end else begin
            ei = m_idx[rc]; em = m_mps[rc];
            tag = (prev_upd >= 0 && prev_upd != rc) ? "R8" : kind_tag(m_kind[rc]);
         end
         lz = lz16(qe_t[ei]);
         nq = (qe_t[ei] << lz) & 'hFFFF;
         chk(tag,  "state idx",  int'(a_idx), ei);
         chk(tag,  "state mps",  int'(a_mps), em);
         chk("R2", "row",        {a_qe, a_nmps, a_nlps, a_sw} , {qe_t[ei][15:0], nm_t[ei][5:0], nl_t[ei][5:0], sw_t[ei][0]});
         chk("R3", "lzc",        int'(a_lzc), lz);
         chk("R4", "qe_norm",    int'(a_norm), nq);
         chk(tag,  "calc idx",   int'({c_mps, c_idx}), (em << 6) | ei);
         chk("R2", "calc row",   {c_qe, c_nmps, c_nlps, c_sw}, {qe_t[ei][15:0], nm_t[ei][5:0], nl_t[ei][5:0], sw_t[ei][0]});
         chk("R3", "calc lzc",   int'(c_lzc), lz);
         chk("R4", "calc norm",  int'(c_norm), nq);
      end
      prev_upd = -1;
      if (r) begin
         for (int c = 0; c < NCTX; c++) begin m_idx[c] = 0; m_mps[c] = 0; m_kind[c] = 1; end
         model_ok = 1'b1;
      end else if (e && uc < NCTX) begin
         ref_next(uc, d, rn, ni, nm, kd);
         m_idx[uc] = ni; m_mps[uc] = nm; m_kind[uc] = kd;
         prev_upd = uc;
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // R1: reset, then every context code, including R10 codes, reads state 0.
      repeat (3) step(1, 0, 0, 0, 0, 0);
      for (int c = 0; c < 32; c++) step(0, 0, 0, 0, 0, c);
      // R9 then R5: LPS on context 3 at row 0 flips sense and moves to row 1.
      step(0, 1, 3, 1'b1, 1'b0, 3);
      step(0, 0, 0, 0, 0, 3);
      // R6 with R8: renormalising MPS on 3 while reading 7, then read 3.
      step(0, 1, 3, 1'b1, 1'b1, 7);
      step(0, 0, 0, 0, 0, 3);
      // R7: plain MPS leaves context 3 alone.
      step(0, 1, 3, 1'b1, 1'b0, 0);
      step(0, 0, 0, 0, 0, 3);
      // Walk context 5 down the MPS chain to row 45 (15 leading zeros).
      for (int i = 0; i < 60; i++) step(0, 1, 5, 1'b0, 1'b1, 5);
      step(0, 0, 0, 0, 0, 5);
      step(0, 1, 5, 1'b1, 1'b0, 5);
      step(0, 0, 0, 0, 0, 5);
      // R10: out-of-range updates are ignored.
      step(0, 1, 25, 1'b1, 1'b1, 25);
      step(0, 1, 31, 1'b0, 1'b1, 3);
      step(0, 0, 0, 0, 0, 3);
      // R1: update presented during reset is discarded.
      step(1, 1, 5, 1'b1, 1'b1, 5);
      step(0, 0, 0, 0, 0, 5);
      for (int i = 0; i < 6000; i++) begin
         int uc, rc;
         uc = $urandom % 22;
         rc = ($urandom % 2 == 0) ? uc : ($urandom % 21);
         step((i % 2500) == 1999, ($urandom % 4) != 0, uc, 1'($urandom), ($urandom % 3) != 0, rc);
      end
      summary();
      $finish;
   end

endmodule